// File: doc/BRIEF.md
# Sixteen-Bit Reload Timer with External Interrupt Capture

This block is a 16-bit up-counter that reloads itself. When the count passes its all-ones value, it takes its next value from a separate 16-bit reload register and sets an overflow flag. The reload register keeps its contents. The counter counts one of two sources. The first is a machine-cycle strobe supplied by the surrounding clock logic. The second is falling transitions on an external count pin, which is sampled only on strobe cycles. Counting can be gated by the level of the first interrupt pin, so that pulse widths can be measured.

The block also contains the capture logic for two external interrupt pins. That logic shares the 8-bit control register. Each pin works in one of two modes. In edge mode, a falling edge sets a flag that stays set until acknowledged. In level mode, the flag tracks the inverted pin. A simple write port and a combinational read port give access to the control register, the two count bytes and the two reload bytes. Three acknowledge inputs clear the flags when the interrupt controller vectors to them.

Top module: `reload_timer16`

## Requirements
- R1: Each enabled count event adds one to the count pair. The low count byte is at address 1 and the high count byte is at address 2.
- R2: An event that finds the count at 0xFFFF loads the count from the reload pair instead of incrementing. The reload low byte is at address 3 and the reload high byte is at address 4. The reload pair keeps its value.
- R3: Events are enabled only while the run bit (control bit 4) is 1. When the gate bit (control bit 7) is 1, events also need irq0_pin to be high. While events are disabled, the count holds.
- R4: The overflow flag (control bit 5, also driven on ovf_flag) is set one clock after a reload. ack_ovf clears it. If a reload and ack_ovf occur in the same cycle, the set wins. A control write loads bit 5 when neither a reload nor ack_ovf occurs.
- R5: When the source bit (control bit 6) is 0, every cycle with mc_tick high is one event.
- R6: When the source bit is 1, cnt_pin is sampled on mc_tick cycles. An event occurs when a sample is 0 and the previous sample was 1, so there is at most one event for every two strobes.
- R7: A write to a count byte takes priority over an event in the same cycle. The written byte takes the data, the other byte keeps its value, and the pair does not advance.
- R8: In edge mode (mode bit = 1; bit 2 for irq0, bit 0 for irq1), a high-to-low change of the pin between two clocks sets the flag (bit 3 for irq0, bit 1 for irq1) one clock later. The flag stays set until its acknowledge input clears it. If an edge and an acknowledge occur in the same cycle, the edge wins.
- R9: In level mode (mode bit = 0), the flag equals the inverted pin level, delayed by one clock. Acknowledges have no effect in this mode.
- R10: Register writes to the two flag bits (3 and 1) have no effect. Reads of addresses 5 to 7 return 0.
- R11: After reset, every register, count and flag reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| cnt_pin | input | 1 | External count source |
| irq0_pin | input | 1 | External interrupt 0, also the count gate |
| irq1_pin | input | 1 | External interrupt 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| ack_ovf | input | 1 | Overflow interrupt acknowledge |
| ack_irq0 | input | 1 | Interrupt 0 acknowledge |
| ack_irq1 | input | 1 | Interrupt 1 acknowledge |
| ovf_flag | output | 1 | Overflow flag |
| irq0_flag | output | 1 | Interrupt 0 flag |
| irq1_flag | output | 1 | Interrupt 1 flag |

## Verification
The assertions check the following on every clock:
- the step-by-one and wrap-to-reload behaviour of the count pair;
- holding while no event occurs;
- write priority on the low count byte;
- the spacing of external-pin events;
- overflow flag set and clear;
- edge latching and level tracking of the interrupt flags.

Only the bench scenarios can show the end-to-end results. These are the gating by irq0_pin, the exact event count produced by a pin waveform, and the read-back of the transposed control layout with its ignored flag bits. A bench reference model runs against random register traffic and confirms that these results agree over long sequences.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;

    localparam int ADDR_W   = 3;
    localparam int BYTE_W   = 8;
    localparam int NUM_IRQ  = 2;

    // register address map
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CNT  = 1;
    localparam int ADDR_REL  = 3;

    // control bit positions (interrupt edge/type bits transposed)
    localparam int B_GATE = 7;
    localparam int B_SRC  = 6;
    localparam int B_OVF  = 5;
    localparam int B_RUN  = 4;
    localparam int B_IE0  = 3;
    localparam int B_IT0  = 2;
    localparam int B_IE1  = 1;
    localparam int B_IT1  = 0;

    typedef struct packed {
        logic gate;
        logic src_ext;
        logic ovf;
        logic run;
        logic it0;
        logic it1;
    } ctrl_t;

endpackage

// File: rtl/tmr_evt_select.sv
`timescale 1ns/1ps
module tmr_evt_select (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic cnt_pin,
    input  logic gate_pin,
    input  logic run,
    input  logic gate,
    input  logic src_ext,
    output logic evt
);

    typedef struct packed {
        logic smp;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic    enabled;
    logic    fall_seen;

    always_comb begin
        st_d      = st_q;
        enabled   = run && (!gate || gate_pin);
        fall_seen = st_q.smp && !cnt_pin;
        if (mc_tick) begin
            st_d.smp = cnt_pin;
        end
        evt = mc_tick && enabled && (src_ext ? fall_seen : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_EXT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext && evt) |=> !(src_ext && evt)); // R6

endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  rel,
    output logic              wrap
);

    localparam int NB = CNT_W / BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     cnt_wr;
    logic     rel_wr;

    always_comb begin
        st_d   = st_q;
        cnt_wr = 1'b0;
        rel_wr = 1'b0;
        wrap   = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (wr_en && wr_addr == ADDR_W'(ADDR_CNT + i)) begin
                st_d.cnt[i*BYTE_W +: BYTE_W] = wr_data;
                cnt_wr = 1'b1;
            end
            if (wr_en && wr_addr == ADDR_W'(ADDR_REL + i)) begin
                st_d.rel[i*BYTE_W +: BYTE_W] = wr_data;
                rel_wr = 1'b1;
            end
        end
        if (!cnt_wr && evt) begin
            if (&st_q.cnt) begin
                st_d.cnt = st_q.rel;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign rel = st_q.rel;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !cnt_wr && !(&st_q.cnt)) |=> st_q.cnt == $past(st_q.cnt) + 1'b1); // R1
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !cnt_wr && !rel_wr && (&st_q.cnt)) |=>
        (st_q.cnt == $past(st_q.rel) && st_q.rel == $past(st_q.rel))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !cnt_wr) |=> $stable(st_q.cnt)); // R3
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADDR_CNT)) |=>
        st_q.cnt[BYTE_W-1:0] == $past(wr_data)); // R7

endmodule

// File: rtl/tmr_irq_capture.sv
`timescale 1ns/1ps
module tmr_irq_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_mode,
    input  logic ack,
    output logic flag
);

    typedef struct packed {
        logic flag;
        logic prev;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin;
        if (edge_mode) begin
            if (ack) begin
                st_d.flag = 1'b0;
            end
            if (st_q.prev && !pin) begin
                st_d.flag = 1'b1;
            end
        end else begin
            st_d.flag = !pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> flag == !$past(pin)); // R9
    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && st_q.prev && !pin) |=> flag); // R8
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && flag && !ack) |=> flag); // R8

endmodule

// File: rtl/reload_timer16.sv
`timescale 1ns/1ps
module reload_timer16
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              cnt_pin,
    input  logic              irq0_pin,
    input  logic              irq1_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ack_ovf,
    input  logic              ack_irq0,
    input  logic              ack_irq1,
    output logic              ovf_flag,
    output logic              irq0_flag,
    output logic              irq1_flag
);

    localparam int NB = CNT_W / BYTE_W;

    ctrl_t              ctrl_d, ctrl_q;
    logic               evt;
    logic               wrap;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   rel;
    logic [NUM_IRQ-1:0] irq_pin_v;
    logic [NUM_IRQ-1:0] irq_mode_v;
    logic [NUM_IRQ-1:0] irq_ack_v;
    logic [NUM_IRQ-1:0] irq_flag_v;

    tmr_evt_select u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .mc_tick  (mc_tick),
        .cnt_pin  (cnt_pin),
        .gate_pin (irq0_pin),
        .run      (ctrl_q.run),
        .gate     (ctrl_q.gate),
        .src_ext  (ctrl_q.src_ext),
        .evt      (evt)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cnt     (cnt),
        .rel     (rel),
        .wrap    (wrap)
    );

    assign irq_pin_v  = {irq1_pin, irq0_pin};
    assign irq_mode_v = {ctrl_q.it1, ctrl_q.it0};
    assign irq_ack_v  = {ack_irq1, ack_irq0};

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        tmr_irq_capture u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (irq_pin_v[g]),
            .edge_mode (irq_mode_v[g]),
            .ack       (irq_ack_v[g]),
            .flag      (irq_flag_v[g])
        );
    end

    // control register next state
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) begin
            ctrl_d.gate    = wr_data[B_GATE];
            ctrl_d.src_ext = wr_data[B_SRC];
            ctrl_d.ovf     = wr_data[B_OVF];
            ctrl_d.run     = wr_data[B_RUN];
            ctrl_d.it0     = wr_data[B_IT0];
            ctrl_d.it1     = wr_data[B_IT1];
        end
        if (ack_ovf) begin
            ctrl_d.ovf = 1'b0;
        end
        if (wrap) begin
            ctrl_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_data[B_GATE] = ctrl_q.gate;
            rd_data[B_SRC]  = ctrl_q.src_ext;
            rd_data[B_OVF]  = ctrl_q.ovf;
            rd_data[B_RUN]  = ctrl_q.run;
            rd_data[B_IE0]  = irq_flag_v[0];
            rd_data[B_IT0]  = ctrl_q.it0;
            rd_data[B_IE1]  = irq_flag_v[1];
            rd_data[B_IT1]  = ctrl_q.it1;
        end
        for (int i = 0; i < NB; i++) begin
            if (rd_addr == ADDR_W'(ADDR_CNT + i)) begin
                rd_data = cnt[i*BYTE_W +: BYTE_W];
            end
            if (rd_addr == ADDR_W'(ADDR_REL + i)) begin
                rd_data = rel[i*BYTE_W +: BYTE_W];
            end
        end
    end

    assign ovf_flag  = ctrl_q.ovf;
    assign irq0_flag = irq_flag_v[0];
    assign irq1_flag = irq_flag_v[1];

    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag); // R4
    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ovf && !wrap) |=> !ovf_flag); // R4

endmodule

// File: tb/test_reload_timer16.sv
`timescale 1ns/1ps
module test_reload_timer16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       irq0_pin = 1'b1;
    logic       irq1_pin = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ack_ovf = 1'b0;
    logic       ack_irq0 = 1'b0;
    logic       ack_irq1 = 1'b0;
    logic       ovf_flag, irq0_flag, irq1_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    reload_timer16 i_reload_timer16 (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
        .irq0_pin(irq0_pin), .irq1_pin(irq1_pin), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ack_ovf(ack_ovf), .ack_irq0(ack_irq0),
        .ack_irq1(ack_irq1), .ovf_flag(ovf_flag), .irq0_flag(irq0_flag),
        .irq1_flag(irq1_flag)
    );

    // reference model state
    logic [15:0] m_cnt, m_rel;
    logic m_gate, m_ct, m_tf, m_tr, m_it0, m_it1, m_ie0, m_ie1;
    logic m_smp, m_p0, m_p1;

    always @(posedge clk) begin : model
        logic ev;
        logic cw;
        logic ov;
        if (!rst_n) begin
            m_cnt = '0; m_rel = '0;
            {m_gate, m_ct, m_tf, m_tr, m_it0, m_it1, m_ie0, m_ie1} = '0;
            {m_smp, m_p0, m_p1} = '0;
        end else begin
            ev = mc_tick && m_tr && (!m_gate || irq0_pin) &&
                 (m_ct ? (m_smp && !cnt_pin) : 1'b1);
            if (mc_tick) m_smp = cnt_pin;
            cw = wr_en && (wr_addr == 3'd1 || wr_addr == 3'd2);
            ov = 1'b0;
            if (cw) begin
                if (wr_addr == 3'd1) m_cnt[7:0] = wr_data;
                else                 m_cnt[15:8] = wr_data;
            end else if (ev) begin
                if (m_cnt == 16'hFFFF) begin
                    m_cnt = m_rel;
                    ov = 1'b1;
                end else begin
                    m_cnt = m_cnt + 16'd1;
                end
            end
            if (wr_en && wr_addr == 3'd3) m_rel[7:0]  = wr_data;
            if (wr_en && wr_addr == 3'd4) m_rel[15:8] = wr_data;
            if (m_it0) m_ie0 = (m_p0 && !irq0_pin) ? 1'b1 : (ack_irq0 ? 1'b0 : m_ie0);
            else       m_ie0 = !irq0_pin;
            if (m_it1) m_ie1 = (m_p1 && !irq1_pin) ? 1'b1 : (ack_irq1 ? 1'b0 : m_ie1);
            else       m_ie1 = !irq1_pin;
            m_p0 = irq0_pin;
            m_p1 = irq1_pin;
            if (wr_en && wr_addr == 3'd0) begin
                m_gate = wr_data[7]; m_ct = wr_data[6]; m_tf = wr_data[5];
                m_tr = wr_data[4]; m_it0 = wr_data[2]; m_it1 = wr_data[0];
            end
            if (ack_ovf) m_tf = 1'b0;
            if (ov)      m_tf = 1'b1;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {m_gate, m_ct, m_tf, m_tr, m_ie0, m_it0, m_ie1, m_it1};
            3'd1: return m_cnt[7:0];
            3'd2: return m_cnt[15:8];
            3'd3: return m_rel[7:0];
            3'd4: return m_rel[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        if (a == 0) return "R4 control byte";
        if (a <= 2) return "R1 count byte";
        if (a <= 4) return "R2 reload byte";
        return "R10 unused address";
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic verify();
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.1;
            check(tag_of(a), 16'(rd_data), 16'(exp_rd(3'(a))));
        end
        check("R4 ovf_flag", 16'(ovf_flag), 16'(m_tf));
        check("R8 irq0_flag", 16'(irq0_flag), 16'(m_ie0));
        check("R9 irq1_flag", 16'(irq1_flag), 16'(m_ie1));
    endtask

    task automatic advance(input int n);
        repeat (n) begin
            @(negedge clk);
            #0.5;
            verify();
        end
    endtask

    task automatic rd16(input logic [2:0] base, output logic [15:0] v);
        rd_addr = base;
        #0.1;
        v[7:0] = rd_data;
        rd_addr = base + 3'd1;
        #0.1;
        v[15:8] = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        advance(1);
        wr_en = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        advance(1);
        // R11: everything zero after reset
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.1;
            check("R11 reset value", 16'(rd_data), 16'h0000);
        end

        // R5 / R2 / R4: internal counting through a wrap
        wr(3'd0, 8'h10);
        wr(3'd3, 8'h34);
        wr(3'd4, 8'h12);
        wr(3'd1, 8'hFE);
        wr(3'd2, 8'hFF);
        mc_tick = 1'b1;
        advance(1);
        rd16(3'd1, v);
        check("R5 strobe step", v, 16'hFFFF);
        advance(2);
        mc_tick = 1'b0;
        rd16(3'd1, v);
        check("R2 wrap to reload", v, 16'h1235);
        rd16(3'd3, v);
        check("R2 reload kept", v, 16'h1234);
        check("R4 flag set on wrap", 16'(ovf_flag), 16'h0001);
        ack_ovf = 1'b1;
        advance(1);
        ack_ovf = 1'b0;
        check("R4 flag cleared by ack", 16'(ovf_flag), 16'h0000);

        // R3: gate from irq0_pin
        wr(3'd0, 8'h90);
        irq0_pin = 1'b0;
        mc_tick = 1'b1;
        advance(4);
        rd16(3'd1, v);
        check("R3 gated hold", v, 16'h1235);
        irq0_pin = 1'b1;
        advance(2);
        mc_tick = 1'b0;
        rd16(3'd1, v);
        check("R3 gate open", v, 16'h1237);

        // R7: write beats increment
        wr(3'd0, 8'h10);
        mc_tick = 1'b1;
        wr(3'd1, 8'h55);
        mc_tick = 1'b0;
        rd16(3'd1, v);
        check("R7 write priority", v, 16'h1255);

        // R6: external pin falling transitions
        wr(3'd0, 8'h50);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        mc_tick = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cnt_pin = (k % 2 == 0);
            advance(1);
        end
        mc_tick = 1'b0;
        rd16(3'd1, v);
        check("R6 pin fall count", v, 16'h0003);

        // R10: flag bits not writable
        wr(3'd0, 8'h0A);
        rd_addr = 3'd0;
        #0.1;
        check("R10 flag bits ignored", 16'(rd_data), 16'h0000);
        rd_addr = 3'd6;
        #0.1;
        check("R10 unused read", 16'(rd_data), 16'h0000);

        // R8: edge capture and acknowledge
        wr(3'd0, 8'h05);
        irq0_pin = 1'b1;
        advance(1);
        irq0_pin = 1'b0;
        advance(1);
        check("R8 edge sets flag", 16'(irq0_flag), 16'h0001);
        irq0_pin = 1'b1;
        advance(2);
        check("R8 flag held", 16'(irq0_flag), 16'h0001);
        ack_irq0 = 1'b1;
        advance(1);
        ack_irq0 = 1'b0;
        check("R8 ack clears", 16'(irq0_flag), 16'h0000);

        // R9: level tracking
        wr(3'd0, 8'h00);
        irq1_pin = 1'b0;
        advance(1);
        check("R9 level low", 16'(irq1_flag), 16'h0001);
        irq1_pin = 1'b1;
        advance(1);
        check("R9 level high", 16'(irq1_flag), 16'h0000);

        // random phase against the model
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'h10);
        for (int it = 0; it < 2500; it++) begin
            mc_tick  = ($urandom_range(2) == 0);
            if ($urandom_range(3) == 0) cnt_pin  = ~cnt_pin;
            if ($urandom_range(5) == 0) irq0_pin = ~irq0_pin;
            if ($urandom_range(5) == 0) irq1_pin = ~irq1_pin;
            ack_ovf  = ($urandom_range(7) == 0);
            ack_irq0 = ($urandom_range(7) == 0);
            ack_irq1 = ($urandom_range(7) == 0);
            wr_en    = ($urandom_range(5) == 0);
            wr_addr  = 3'($urandom_range(7));
            wr_data  = 8'($urandom);
            if ((wr_addr == 3'd2 || wr_addr == 3'd4) && $urandom_range(1) == 0)
                wr_data = 8'hFF;
            if (wr_addr == 3'd0 && $urandom_range(3) != 0)
                wr_data[4] = 1'b1;
            advance(1);
        end
        wr_en = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule